// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip request port and an external 128K x 8 asynchronous static RAM. It takes one word at a time through a valid/ready handshake, with a write flag, a 17-bit address and a byte of write data. It then plays out the matching strobe sequence on the RAM pins and ends each transaction with a one-cycle done pulse. On a read, the done pulse carries the byte that was fetched.

The RAM is selected only while its active-low chip enable is low and its active-high chip enable is high. Every minimum or maximum time the RAM needs is a nanosecond parameter. At elaboration each one becomes a whole number of clock cycles: the value divided by the clock period, rounded up, and never less than one.

The sequence is built from fixed phases: address setup, read access, write turnaround, write pulse, write hold and completion. The address only moves while the RAM is deselected. The controller's data drivers are never on while the RAM's output enable is low. The data pins are split into a driven value, a drive enable and a sampled input, and the pad tri-state is built from those three signals.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and in the first idle cycle after it, the RAM pins are inactive (ram_ce_n=1, ram_ce=0, ram_we_n=1, ram_oe_n=1), ram_dq_oe=0 and rsp_done=0.
- R2: req_ready is high only in the idle phase, where all strobes are inactive. A request is taken on the clock edge where req_valid and req_ready are both high. A request held while busy waits, and changes to the request fields while busy do not affect the transaction in progress.
- R3: The address is loaded on the accepting edge. A setup phase of ceil(T_AS/period) cycles (minimum one) follows, with all strobes inactive. ram_addr does not change while both chip enables are active.
- R4: A read holds ram_ce_n=0, ram_ce=1, ram_oe_n=0 and ram_we_n=1 for max(ceil(T_RC), ceil(T_AA), ceil(T_OE)) cycles, each count rounded up and at least one (9 cycles with the defaults and an 8 ns clock).
- R5: Read data is sampled from ram_dq_in on the edge that ends the read window, while the strobes are still active. It appears on rsp_rdata in the completion cycle that follows, where rsp_done is high for exactly one cycle with all strobes inactive.
- R6: A write starts with a turnaround phase of ceil(T_WHZ) cycles (4 with the defaults). In this phase the chip enables are active, ram_we_n=0, ram_oe_n=1 and ram_dq_oe=0.
- R7: The pulse phase then drives the write data with ram_dq_oe=1 and ram_we_n=0 for max(ceil(T_DW), ceil(T_WP)-turnaround, 1) cycles (5 with the defaults). Write enable stays low for at least ceil(T_WP) cycles in all, and the data is driven for at least ceil(T_DW) of them.
- R8: After write enable rises, the chip enables and the data drive are held for max(ceil(T_DH), ceil(T_WR), ceil(T_WC)-turnaround-pulse, 1) cycles (1 with the defaults). The completion cycle follows, with rsp_done=1, the drive released and the RAM deselected.
- R9: ram_dq_oe is never high while ram_oe_n is low, and ram_oe_n stays high through every write phase.
- R10: A byte written to an address is returned by a later read of that address, and a later write to the same address replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte fetched by the last read |
| ram_addr | output | 17 | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip enable |
| ram_ce | output | 1 | Active-high chip enable |
| ram_we_n | output | 1 | Active-low write enable |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | 8 | Value for the data pads to drive |
| ram_dq_oe | output | 1 | Data pad drive enable |
| ram_dq_in | input | 8 | Value sampled from the data pads |

## Verification
The bench models the RAM with a latency. It returns the stored byte only after the read strobes have been active for the full access count, and returns filler before that. A controller that samples one edge early therefore returns the wrong byte.

The RAM model also commits a write only when write enable rises with the chip selected. It measures how long write enable was low and how long data was driven before the rise. A pulse or setup phase that is too short shows up there, and a hold that drops the chip enable first shows up as missing data on read-back.

Requests are offered back to back with the fields scrambled while the controller is busy. A design that accepted early, or took the address from the live request port instead of its latch, would move ram_addr under an active enable. Reads of unwritten and overwritten locations and of both address extremes complete the cases.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASET,
        PH_RD_ACC,
        PH_WR_TURN,
        PH_WR_PULSE,
        PH_WR_HOLD,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    // Nanoseconds to clock cycles, rounded up, at least one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for each phase of the sequence.
    function automatic strobe_t phase_strobes(input phase_e ph);
        strobe_t s;
        s.ce_n  = 1'b1;
        s.ce    = 1'b0;
        s.we_n  = 1'b1;
        s.oe_n  = 1'b1;
        s.dq_oe = 1'b0;
        case (ph)
            PH_RD_ACC: begin
                s.ce_n = 1'b0;
                s.ce   = 1'b1;
                s.oe_n = 1'b0;
            end
            PH_WR_TURN: begin
                s.ce_n = 1'b0;
                s.ce   = 1'b1;
                s.we_n = 1'b0;
            end
            PH_WR_PULSE: begin
                s.ce_n  = 1'b0;
                s.ce    = 1'b1;
                s.we_n  = 1'b0;
                s.dq_oe = 1'b1;
            end
            PH_WR_HOLD: begin
                s.ce_n  = 1'b0;
                s.ce    = 1'b1;
                s.dq_oe = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // A phase loaded with N lasts exactly N cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int ASET_CYC  = 1,
    parameter int RD_CYC    = 9,
    parameter int TURN_CYC  = 4,
    parameter int PULSE_CYC = 5,
    parameter int HOLD_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             expired,
    output phase_e           phase,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             accept,
    output logic             capture
);

    phase_e ph_q;
    phase_e ph_d;
    logic   wr_q;

    assign accept  = (ph_q == PH_IDLE) && req_valid;
    assign capture = (ph_q == PH_RD_ACC) && expired;
    assign phase   = ph_q;

    always_comb begin
        ph_d     = ph_q;
        load     = 1'b0;
        load_val = '0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    ph_d     = PH_ASET;
                    load     = 1'b1;
                    load_val = CNT_W'(ASET_CYC);
                end
            end
            PH_ASET: begin
                if (expired) begin
                    load = 1'b1;
                    if (wr_q) begin
                        ph_d     = PH_WR_TURN;
                        load_val = CNT_W'(TURN_CYC);
                    end else begin
                        ph_d     = PH_RD_ACC;
                        load_val = CNT_W'(RD_CYC);
                    end
                end
            end
            PH_RD_ACC: begin
                if (expired) begin
                    ph_d     = PH_FIN;
                    load     = 1'b1;
                    load_val = CNT_W'(1);
                end
            end
            PH_WR_TURN: begin
                if (expired) begin
                    ph_d     = PH_WR_PULSE;
                    load     = 1'b1;
                    load_val = CNT_W'(PULSE_CYC);
                end
            end
            PH_WR_PULSE: begin
                if (expired) begin
                    ph_d     = PH_WR_HOLD;
                    load     = 1'b1;
                    load_val = CNT_W'(HOLD_CYC);
                end
            end
            PH_WR_HOLD: begin
                if (expired) begin
                    ph_d     = PH_FIN;
                    load     = 1'b1;
                    load_val = CNT_W'(1);
                end
            end
            PH_FIN: begin
                if (expired) begin
                    ph_d = PH_IDLE;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
            wr_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (accept) begin
                wr_q <= req_write;
            end
        end
    end

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr  <= '0;
            wdata <= '0;
            rdata <= '0;
        end else begin
            if (accept) begin
                addr  <= req_addr;
                wdata <= req_wdata;
            end
            if (capture) begin
                rdata <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS  = 8,
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 8,
    parameter int T_RC_NS = 70,
    parameter int T_AA_NS = 70,
    parameter int T_OE_NS = 35,
    parameter int T_WC_NS = 70,
    parameter int T_WP_NS = 50,
    parameter int T_AS_NS = 0,
    parameter int T_WR_NS = 5,
    parameter int T_DW_NS = 35,
    parameter int T_DH_NS = 0,
    parameter int T_WHZ_NS = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_ce,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int ASET_CYC  = ns_to_cyc(T_AS_NS, CLK_NS);
    localparam int RD_CYC    = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                    ns_to_cyc(T_OE_NS, CLK_NS));
    localparam int TURN_CYC  = ns_to_cyc(T_WHZ_NS, CLK_NS);
    localparam int PULSE_CYC = imax(ns_to_cyc(T_DW_NS, CLK_NS),
                                    imax(ns_to_cyc(T_WP_NS, CLK_NS) - TURN_CYC, 1));
    localparam int HOLD_CYC  = imax(imax(ns_to_cyc(T_DH_NS, CLK_NS), ns_to_cyc(T_WR_NS, CLK_NS)),
                                    imax(ns_to_cyc(T_WC_NS, CLK_NS) - TURN_CYC - PULSE_CYC, 1));
    localparam int MAX_CYC   = imax(imax(imax(ASET_CYC, RD_CYC), imax(TURN_CYC, PULSE_CYC)), HOLD_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    phase_e           phase;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             expired;
    logic             accept;
    logic             capture;
    strobe_t          stb;

    sram_ctl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctl_seq #(
        .CNT_W     (CNT_W),
        .ASET_CYC  (ASET_CYC),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .phase     (phase),
        .load      (load),
        .load_val  (load_val),
        .accept    (accept),
        .capture   (capture)
    );

    sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (ram_dq_in),
        .addr      (ram_addr),
        .wdata     (ram_dq_out),
        .rdata     (rsp_rdata)
    );

    assign stb       = phase_strobes(phase);
    assign ram_ce_n  = stb.ce_n;
    assign ram_ce    = stb.ce;
    assign ram_we_n  = stb.we_n;
    assign ram_oe_n  = stb.oe_n;
    assign ram_dq_oe = stb.dq_oe;
    assign req_ready = (phase == PH_IDLE);
    assign rsp_done  = (phase == PH_FIN);

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_ce_n,
    input logic              ram_ce,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              ram_dq_oe
);

    logic sel;
    assign sel = !ram_ce_n && ram_ce;

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ram_ce_n && !ram_ce && ram_we_n && ram_oe_n && !ram_dq_oe));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(ram_addr));

    p_addr_move_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ram_addr) |-> !sel);

    p_we_high_read_r4: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> ram_we_n);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_drive_late_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_dq_oe) |-> (!ram_we_n && $past(!ram_we_n)));

    p_release_done_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!ram_dq_oe && !sel));

    p_no_fight_r9: assert property (@(posedge clk) disable iff (rst)
        !(ram_dq_oe && !ram_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_ce    (ram_ce),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;

    localparam int PER = 8;
    localparam int AW  = 17;
    localparam int DW  = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int C_AS    = cyc(0);
    localparam int C_AA    = cyc(70);
    localparam int C_RD    = mx(mx(cyc(70), C_AA), cyc(35));
    localparam int C_TURN  = cyc(25);
    localparam int C_WP    = cyc(50);
    localparam int C_DW    = cyc(35);
    localparam int C_PULSE = mx(C_DW, mx(C_WP - C_TURN, 1));
    localparam int C_HOLD  = mx(mx(cyc(0), cyc(5)), mx(cyc(70) - C_TURN - C_PULSE, 1));

    // strobe order {ce_n, ce, we_n, oe_n, dq_oe}
    localparam logic [4:0] S_OFF   = 5'b10110;
    localparam logic [4:0] S_READ  = 5'b01100;
    localparam logic [4:0] S_TURN  = 5'b01010;
    localparam logic [4:0] S_PULSE = 5'b01011;
    localparam logic [4:0] S_HOLD  = 5'b01111;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] ram_addr;
    logic          ram_ce_n;
    logic          ram_ce;
    logic          ram_we_n;
    logic          ram_oe_n;
    logic [DW-1:0] ram_dq_out;
    logic          ram_dq_oe;
    logic [DW-1:0] ram_dq_in = 8'hEE;

    always #4 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .ram_addr   (ram_addr),
        .ram_ce_n   (ram_ce_n),
        .ram_ce     (ram_ce),
        .ram_we_n   (ram_we_n),
        .ram_oe_n   (ram_oe_n),
        .ram_dq_out (ram_dq_out),
        .ram_dq_oe  (ram_dq_oe),
        .ram_dq_in  (ram_dq_in)
    );

    typedef struct packed {
        logic [4:0]    stb;
        logic          rdy;
        logic          dn;
        logic [AW-1:0] a;
        logic          use_d;
        logic [DW-1:0] d;
    } exp_t;

    exp_t          q[$];
    string         tq[$];
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] ram [int];
    int            n_chk = 0;
    int            n_fail = 0;
    int            rd_act = 0;
    int            we_len = 0;
    int            drv_len = 0;
    logic [DW-1:0] wdat = '0;
    int            cycles = 0;
    bit            finished = 0;

    function automatic void check(input bit ok, input string tag, input string what,
                                  input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    function automatic void push(input logic [4:0] s, input bit dn, input logic [AW-1:0] a,
                                 input bit use_d, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.stb = s; e.rdy = 1'b0; e.dn = dn; e.a = a; e.use_d = use_d; e.d = d;
        q.push_back(e);
        tq.push_back(tag);
    endfunction

    // Reference comparison and RAM model, once per cycle away from the edge.
    always @(negedge clk) begin
        exp_t       e;
        string      t;
        logic [4:0] act;
        bit         sel;
        act = {ram_ce_n, ram_ce, ram_we_n, ram_oe_n, ram_dq_oe};
        sel = !ram_ce_n && ram_ce;
        if (rst) begin
            check(act == S_OFF && !rsp_done, "R1", "strobes in reset", {27'b0, act}, {27'b0, S_OFF});
            rd_act = 0; we_len = 0; drv_len = 0; ram_dq_in = 8'hEE;
        end else begin
            if (q.size() > 0) begin
                e = q.pop_front();
                t = tq.pop_front();
            end else begin
                e = '0; e.stb = S_OFF; e.rdy = 1'b1;
                t = "R1 R2";
            end
            check(act == e.stb && req_ready == e.rdy && rsp_done == e.dn, t, "strobes/ready/done",
                  {25'b0, act, req_ready, rsp_done}, {25'b0, e.stb, e.rdy, e.dn});
            if (!e.rdy)
                check(ram_addr == e.a, "R3", "address", {15'b0, ram_addr}, {15'b0, e.a});
            if (e.use_d && e.dn)
                check(rsp_rdata == e.d, "R5 R10", "read data", {24'b0, rsp_rdata}, {24'b0, e.d});
            if (e.use_d && !e.dn)
                check(ram_dq_out == e.d, "R7", "driven data", {24'b0, ram_dq_out}, {24'b0, e.d});
            // write side of the RAM: commit on the rise of write enable
            if (sel && !ram_we_n) begin
                we_len++;
                if (ram_dq_oe) begin
                    drv_len++;
                    wdat = ram_dq_out;
                end
            end else if (we_len > 0) begin
                check(we_len >= C_WP, "R7", "write pulse cycles", we_len, C_WP);
                check(drv_len >= C_DW, "R7", "data setup cycles", drv_len, C_DW);
                if (sel) ram[int'(ram_addr)] = wdat;
                we_len = 0; drv_len = 0;
            end
            // read side: valid data only after the full access time
            if (sel && !ram_oe_n && ram_we_n) begin
                if (rd_act >= C_AA - 1)
                    ram_dq_in = ram.exists(int'(ram_addr)) ? ram[int'(ram_addr)] : 8'h00;
                else
                    ram_dq_in = 8'hEE;
                rd_act++;
            end else begin
                rd_act = 0;
                ram_dq_in = 8'hEE;
            end
        end
    end

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] exp_rd;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        for (int i = 0; i < C_AS; i++) push(S_OFF, 0, a, 0, '0, "R3");
        if (w) begin
            ref_mem[int'(a)] = d;
            for (int i = 0; i < C_TURN; i++)  push(S_TURN, 0, a, 0, '0, "R6");
            for (int i = 0; i < C_PULSE; i++) push(S_PULSE, 0, a, 1, d, "R7");
            for (int i = 0; i < C_HOLD; i++)  push(S_HOLD, 0, a, 1, d, "R8");
            push(S_OFF, 1, a, 0, '0, "R8");
        end else begin
            exp_rd = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
            for (int i = 0; i < C_RD; i++) push(S_READ, 0, a, 0, '0, "R4");
            push(S_OFF, 1, a, 1, exp_rd, "R5");
        end
        @(negedge clk); #1;
        // scrambled fields while busy must have no effect
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        issue(1, 17'h00000, 8'hA5);
        issue(1, 17'h1FFFF, 8'h3C);
        issue(1, 17'h0AAAA, 8'h5A);
        issue(0, 17'h0AAAA, 8'h00);
        issue(0, 17'h00000, 8'h00);
        issue(0, 17'h1FFFF, 8'h00);
        issue(0, 17'h12345, 8'h00);
        issue(1, 17'h00000, 8'hFF);
        issue(0, 17'h00000, 8'h00);
        issue(1, 17'h15555, 8'h00);
        issue(0, 17'h15555, 8'h11);
        for (int i = 1; i < 9; i++) issue(1, AW'(i * 4099), DW'(i * 37));
        for (int i = 8; i > 0; i--) issue(0, AW'(i * 4099), 8'h00);
        while (q.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: got busy expected idle");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule